// File: doc/BRIEF.md
# UART CPU Register Interface

This block sits between an 8-bit asynchronous processor bus and the transmit and receive paths of a UART. Each bus input is retimed into the system clock domain through a two-stage flop chain. The retimed chip select, register select and active-low read and write strobes are then decoded into four single-cycle actions. With the register select low, the processor reads a 3-bit status word or writes a 3-bit interrupt-enable mask. With the register select high, a write pushes a byte toward the transmit FIFO and a read pops a byte from the receive FIFO.

Each access starts its action on the falling edge of the retimed strobe. A long strobe therefore still moves exactly one byte. Read data is captured into an output register, and that register drives the shared bidirectional data bus only while the read is in progress. The interrupt output is active low and registered. It is the OR of the status bits, each gated by its enable bit.

Top module: `uart_cpu_regif`

## Requirements
- R1: No bus input (register select, chip select, strobes, data) affects any output before it has passed two clock edges. A write strobe that goes low just before a clock edge produces its transmit push on the third clock edge after it, not on the second.
- R2: A write with register select low loads data bits 2..0 into the interrupt-enable mask. Bits 7..3 are ignored.
- R3: A read with register select low puts the status word on the data bus. Bit 0 is transmit-ready, bit 1 is receive-ready, bit 2 is the parity-error flag, and bits 7..3 read as zero.
- R4: A write with register select high raises `txPush` for one clock cycle, with `txByte` equal to the written byte.
- R5: A read with register select high raises `rxPop` for one clock cycle and drives the byte present on `rxByte` onto the data bus.
- R6: `intN` is low exactly when at least one status bit and its matching enable bit are both 1. It is updated one clock after the status or the mask changes.
- R7: The block drives the data bus only while a read is active. At all other times the bus is high impedance and another driver's value reads back unchanged.
- R8: Each access produces at most one push or pop, however long the strobe is held low.
- R9: An active-low asynchronous reset clears the mask and releases the bus. After reset `intN` stays high even with all status bits set, and `txPush` and `rxPop` are low.
- R10: Strobes that arrive while chip select is high are ignored. They cause no push, no pop and no change to the mask.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| regSel | input | 1 | Register select: 0 = status/mask, 1 = data |
| csN | input | 1 | Chip select, active low |
| wrN | input | 1 | Write strobe, active low |
| rdN | input | 1 | Read strobe, active low |
| dataBus | inout | 8 | Bidirectional processor data bus |
| txReady | input | 1 | Status bit 0: transmit FIFO has room |
| rxReady | input | 1 | Status bit 1: receive FIFO holds data |
| parityErr | input | 1 | Status bit 2: parity error seen |
| rxByte | input | 8 | Head byte of the receive FIFO |
| txPush | output | 1 | One-cycle push strobe to the transmit FIFO |
| txByte | output | 8 | Byte to push into the transmit FIFO |
| rxPop | output | 1 | One-cycle pop strobe to the receive FIFO |
| intN | output | 1 | Interrupt request, active low |

## Verification
On every cycle, the assertions check that the decoded actions are mutually exclusive and that push and pop pulses never last two cycles. They also check that each pulse follows a decoded action of the matching kind, that the bus is driven only after a cycle with the read strobe low, and that a clear mask keeps the interrupt released. Only the bench scenarios can show the rest. That covers the three-edge retiming latency, the exact bytes on the bus and on the push port, the bit-level masking of the interrupt, and the way strobes without chip select are ignored.

// File: rtl/regif_pkg.sv
package regif_pkg;
  localparam int DATA_W = 8;
  localparam int STS_W  = 3;

  typedef struct packed {
    logic maskWrite;
    logic dataWrite;
    logic statusRead;
    logic dataRead;
  } regifStrobes_t;
endpackage

// File: rtl/regif_sync.sv
module regif_sync #(
  parameter int WIDTH = 1,
  parameter logic [WIDTH-1:0] RESET_VAL = '0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [WIDTH-1:0] asyncIn,
  output logic [WIDTH-1:0] syncOut
);
  logic [WIDTH-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1  <= RESET_VAL;
      syncOut <= RESET_VAL;
    end else begin
      stage1  <= asyncIn;
      syncOut <= stage1;
    end
  end
endmodule

// File: rtl/regif_ctrl.sv
module regif_ctrl
  import regif_pkg::*;
(
  input  logic          clk,
  input  logic          rstN,
  input  logic          selS,
  input  logic          csS,
  input  logic          wrS,
  input  logic          rdS,
  output regifStrobes_t strobes,
  output logic          rdHold
);
  logic wrPrev, rdPrev;
  logic wrFall, rdFall;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      wrPrev <= 1'b1;
      rdPrev <= 1'b1;
    end else begin
      wrPrev <= wrS;
      rdPrev <= rdS;
    end
  end

  // act once on the falling edge of a strobe, only when selected
  assign wrFall = wrPrev && !wrS && !csS;
  assign rdFall = rdPrev && !rdS && !csS;

  always_comb begin
    strobes.maskWrite  = wrFall && !selS;
    strobes.dataWrite  = wrFall && selS;
    strobes.statusRead = rdFall && !selS;
    strobes.dataRead   = rdFall && selS;
  end

  assign rdHold = !rdS && !csS;

  // R8: a strobe level never yields two consecutive actions of one kind
  p_one_action_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));
  p_no_repeat_write_r8: assert property (@(posedge clk) disable iff (!rstN)
    (strobes.dataWrite || strobes.maskWrite) |=> !(strobes.dataWrite || strobes.maskWrite));
endmodule

// File: rtl/regif_dpath.sv
module regif_dpath
  import regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  regifStrobes_t     strobes,
  input  logic              rdHold,
  input  logic [DATA_W-1:0] dataS,
  input  logic [STS_W-1:0]  status,
  input  logic [DATA_W-1:0] rxByte,
  output logic              txPush,
  output logic [DATA_W-1:0] txByte,
  output logic              rxPop,
  output logic [DATA_W-1:0] readReg,
  output logic              driveEn,
  output logic              intN
);
  logic [STS_W-1:0] maskReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      maskReg <= '0;
      txPush  <= 1'b0;
      txByte  <= '0;
      rxPop   <= 1'b0;
      readReg <= '0;
      driveEn <= 1'b0;
      intN    <= 1'b1;
    end else begin
      txPush <= strobes.dataWrite;
      rxPop  <= strobes.dataRead;
      if (strobes.maskWrite) maskReg <= dataS[STS_W-1:0];
      if (strobes.dataWrite) txByte  <= dataS;
      if (strobes.statusRead) readReg <= {{(DATA_W-STS_W){1'b0}}, status};
      else if (strobes.dataRead) readReg <= rxByte;
      if (strobes.statusRead || strobes.dataRead) driveEn <= 1'b1;
      else if (!rdHold) driveEn <= 1'b0;
      intN <= !(|(status & maskReg));
    end
  end

  p_push_single_r4: assert property (@(posedge clk) disable iff (!rstN)
    txPush |=> !txPush);
  p_pop_single_r5: assert property (@(posedge clk) disable iff (!rstN)
    rxPop |=> !rxPop);
  p_push_from_write_r4: assert property (@(posedge clk) disable iff (!rstN)
    txPush |-> $past(strobes.dataWrite));
  p_drive_in_read_r7: assert property (@(posedge clk) disable iff (!rstN)
    driveEn |-> $past(rdHold));
  p_masked_quiet_r6: assert property (@(posedge clk) disable iff (!rstN)
    (maskReg == '0) |=> intN);
endmodule

// File: rtl/uart_cpu_regif.sv
module uart_cpu_regif
  import regif_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              regSel,
  input  logic              csN,
  input  logic              wrN,
  input  logic              rdN,
  inout  wire  [DATA_W-1:0] dataBus,
  input  logic              txReady,
  input  logic              rxReady,
  input  logic              parityErr,
  input  logic [DATA_W-1:0] rxByte,
  output logic              txPush,
  output logic [DATA_W-1:0] txByte,
  output logic              rxPop,
  output logic              intN
);
  logic [3:0]        ctlS;
  logic [DATA_W-1:0] dataS;
  logic [DATA_W-1:0] readReg;
  logic              driveEn;
  logic              rdHold;
  regifStrobes_t     strobes;

  regif_sync #(.WIDTH(4), .RESET_VAL(4'b0111)) uCtlSync (
    .clk(clk), .rstN(rstN),
    .asyncIn({regSel, csN, wrN, rdN}), .syncOut(ctlS)
  );

  regif_sync #(.WIDTH(DATA_W), .RESET_VAL('0)) uDataSync (
    .clk(clk), .rstN(rstN), .asyncIn(dataBus), .syncOut(dataS)
  );

  regif_ctrl uCtrl (
    .clk(clk), .rstN(rstN),
    .selS(ctlS[3]), .csS(ctlS[2]), .wrS(ctlS[1]), .rdS(ctlS[0]),
    .strobes(strobes), .rdHold(rdHold)
  );

  regif_dpath uDpath (
    .clk(clk), .rstN(rstN), .strobes(strobes), .rdHold(rdHold),
    .dataS(dataS), .status({parityErr, rxReady, txReady}), .rxByte(rxByte),
    .txPush(txPush), .txByte(txByte), .rxPop(rxPop),
    .readReg(readReg), .driveEn(driveEn), .intN(intN)
  );

  assign dataBus = driveEn ? readReg : 'z;
endmodule

// File: tb/uart_cpu_regif_test.sv
module uart_cpu_regif_test;
  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rstN, regSel, csN, wrN, rdN, cpuDrv;
  logic [7:0] cpuData, rxByte, txByte;
  logic txReady, rxReady, parityErr, txPush, rxPop, intN;
  wire  [7:0] dataBus;
  assign dataBus = cpuDrv ? cpuData : 'z;

  int tests = 0, fails = 0;
  bit done = 1'b0;

  uart_cpu_regif uut (
    .clk(clk), .rstN(rstN), .regSel(regSel), .csN(csN), .wrN(wrN), .rdN(rdN),
    .dataBus(dataBus), .txReady(txReady), .rxReady(rxReady), .parityErr(parityErr),
    .rxByte(rxByte), .txPush(txPush), .txByte(txByte), .rxPop(rxPop), .intN(intN)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic access(input bit wr, input bit sel, input logic [7:0] wd, input int hold,
                        input bit cs, output int pushes, output int pops,
                        output logic [7:0] lastTx, output logic [7:0] busVal);
    @(negedge clk);
    csN = !cs; regSel = sel;
    if (wr) begin cpuData = wd; cpuDrv = 1'b1; wrN = 1'b0; end
    else rdN = 1'b0;
    pushes = 0; pops = 0; lastTx = 8'h00; busVal = 8'h00;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      pushes += int'(txPush); pops += int'(rxPop);
      if (txPush) lastTx = txByte;
      busVal = dataBus;
    end
    wrN = 1'b1; rdN = 1'b1; csN = 1'b1; cpuDrv = 1'b0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      pushes += int'(txPush); pops += int'(rxPop);
      if (txPush) lastTx = txByte;
    end
  endtask

  typedef struct packed {
    logic       isWr;
    logic       sel;
    logic [7:0] wd;
    logic [2:0] sts;
    logic [7:0] rxb;
    logic [7:0] expBus;
    logic       expPush;
    logic       expPop;
  } vec_t;

  localparam int NV = 6;
  localparam vec_t VECS [NV] = '{
    '{1'b1, 1'b0, 8'hF9, 3'b000, 8'h00, 8'h00, 1'b0, 1'b0},  // R2 mask write
    '{1'b0, 1'b0, 8'h00, 3'b011, 8'h00, 8'h03, 1'b0, 1'b0},  // R3 status read
    '{1'b1, 1'b1, 8'hA5, 3'b000, 8'h00, 8'h00, 1'b1, 1'b0},  // R4 data write
    '{1'b0, 1'b1, 8'h00, 3'b000, 8'h5C, 8'h5C, 1'b0, 1'b1},  // R5 data read
    '{1'b0, 1'b0, 8'h00, 3'b100, 8'hEE, 8'h04, 1'b0, 1'b0},  // R3 parity bit
    '{1'b1, 1'b1, 8'h3C, 3'b000, 8'h00, 8'h00, 1'b1, 1'b0}   // R4 second byte
  };

  initial begin
    #(200000 * 10);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int pu, po;
    logic [7:0] tx, bv;
    rstN = 1'b0; regSel = 1'b0; csN = 1'b1; wrN = 1'b1; rdN = 1'b1; cpuDrv = 1'b0;
    cpuData = 8'h00; rxByte = 8'h00; txReady = 1'b1; rxReady = 1'b1; parityErr = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 intN in reset", 32'(intN), 32'd1);
    chk("R9 txPush in reset", 32'(txPush), 32'd0);
    chk("R9 rxPop in reset", 32'(rxPop), 32'd0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 mask clear, all status set", 32'(intN), 32'd1);

    // table-driven accesses
    for (int k = 0; k < NV; k++) begin
      {parityErr, rxReady, txReady} = VECS[k].sts;
      rxByte = VECS[k].rxb;
      access(VECS[k].isWr, VECS[k].sel, VECS[k].wd, 4, 1'b1, pu, po, tx, bv);
      chk($sformatf("R4/R8 push count vec%0d", k), 32'(pu), 32'(VECS[k].expPush));
      chk($sformatf("R5/R8 pop count vec%0d", k), 32'(po), 32'(VECS[k].expPop));
      if (VECS[k].isWr && VECS[k].expPush) chk($sformatf("R4 txByte vec%0d", k), 32'(tx), 32'(VECS[k].wd));
      if (!VECS[k].isWr) chk($sformatf("R3/R5 bus vec%0d", k), 32'(bv), 32'(VECS[k].expBus));
    end

    // R2/R6: mask = 3'b001 from 8'hF9 (upper bits ignored)
    @(negedge clk); {parityErr, rxReady, txReady} = 3'b110;
    @(negedge clk); @(negedge clk);
    chk("R2 upper data bits ignored, intN", 32'(intN), 32'd1);
    {parityErr, rxReady, txReady} = 3'b001;
    @(negedge clk);
    chk("R6 intN one clock after status", 32'(intN), 32'd0);
    {parityErr, rxReady, txReady} = 3'b000;
    @(negedge clk);
    chk("R6 intN released", 32'(intN), 32'd1);
    access(1'b1, 1'b0, 8'h04, 4, 1'b1, pu, po, tx, bv);
    {parityErr, rxReady, txReady} = 3'b011;
    @(negedge clk); @(negedge clk);
    chk("R6 unmasked bits only, intN", 32'(intN), 32'd1);
    parityErr = 1'b1;
    @(negedge clk); @(negedge clk);
    chk("R6 parity enabled, intN", 32'(intN), 32'd0);

    // R10: write with chip select high does not touch mask or push
    access(1'b1, 1'b0, 8'h00, 4, 1'b0, pu, po, tx, bv);
    chk("R10 mask kept, intN", 32'(intN), 32'd0);
    access(1'b1, 1'b1, 8'h77, 4, 1'b0, pu, po, tx, bv);
    chk("R10 no push", 32'(pu), 32'd0);
    access(1'b0, 1'b1, 8'h00, 4, 1'b0, pu, po, tx, bv);
    chk("R10 no pop", 32'(po), 32'd0);

    // R1: push appears on third edge after strobe
    @(negedge clk);
    csN = 1'b0; regSel = 1'b1; cpuDrv = 1'b1; cpuData = 8'h81; wrN = 1'b0;
    @(negedge clk); chk("R1 no push after 1 edge", 32'(txPush), 32'd0);
    @(negedge clk); chk("R1 no push after 2 edges", 32'(txPush), 32'd0);
    @(negedge clk); chk("R1 push after 3 edges", 32'(txPush), 32'd1);
    chk("R1 byte after 3 edges", 32'(txByte), 32'h81);
    wrN = 1'b1; csN = 1'b1; cpuDrv = 1'b0;
    repeat (5) @(negedge clk);

    // R8: long strobes
    access(1'b1, 1'b1, 8'h42, 30, 1'b1, pu, po, tx, bv);
    chk("R8 long write one push", 32'(pu), 32'd1);
    rxByte = 8'hB7;
    access(1'b0, 1'b1, 8'h00, 30, 1'b1, pu, po, tx, bv);
    chk("R8 long read one pop", 32'(po), 32'd1);
    chk("R5 long read bus", 32'(bv), 32'hB7);

    // R7: bus released when idle
    @(negedge clk); cpuDrv = 1'b1; cpuData = 8'h96;
    @(negedge clk); chk("R7 bus high impedance idle", 32'(dataBus), 32'h96);
    cpuDrv = 1'b0;

    // R9: reset clears mask
    rstN = 1'b0; {parityErr, rxReady, txReady} = 3'b111;
    @(negedge clk); rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R9 mask cleared by reset", 32'(intN), 32'd1);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule